// File: doc/BRIEF.md
# Chainable Byte-Framed SPI Register Slave

This block is the serial control front end of a five-channel high-side switch controller. A host drives chip select, serial clock and serial data in. The block holds the controller's four small configuration registers and returns a diagnosis byte or a register value on serial data out. Each frame must be a whole number of bytes. When it is, the last byte held in the shift register is decoded as a command when chip select rises. When it is not, the command is dropped and a transmission-error flag is raised. That flag is shown on serial data out before the first clock edge of the following frame, and again as the top bit of the response byte.

All SPI pins are oversampled by the system clock through two-stage synchronizers. The edges of the serial clock and of chip select are detected on the synchronized signals. Serial data in is sampled on the falling edge of the serial clock, and serial data out changes on the rising edge. Both run most significant bit first. The shift register is exactly one byte long, so several devices can be chained on one select line. Each device passes earlier bytes through to its output eight clocks later and acts only on the byte it holds at the end of the frame.

A register read takes two frames. The first frame names the register. The response appears during the second frame, and that frame may itself carry a new command. When no read is pending, the standard diagnosis byte is returned. It holds the error flag, the limp-home input level and the five channel error inputs.

Top module: `chain_spi_regs`

## Requirements
- R1: Serial data in is sampled on the falling serial-clock edge and the response is shifted out on the rising edge, both MSB first. While chip select is high, `soOe` is 0 and serial-clock pulses are not counted.
- R2: From the fall of chip select until the first rising serial-clock edge, `so` equals the transmission-error flag ORed with the present level of `si`.
- R3: When chip select rises, the frame is accepted only if the number of serial-clock pulses since chip select fell is a nonzero multiple of 8. Any other frame, including one with zero pulses, changes no register and sets the error flag.
- R4: The error flag is 1 after reset and after a rejected frame, and 0 after an accepted frame. It is bit 7 of every response byte.
- R5: A command byte with bit 7 at 1 is a write. Bits 6:5 give the address and bits 4:0 the data. Address 00 holds the output enables, all bits (reset 0). Address 01 holds the LED-mode bits for channels 0 to 2, in data bits 2:0 (reset 0). Address 10 holds the PWM combine mode in data bit 1 (reset 0). Address 11 holds the 3-bit sense select in data bits 2:0 (reset 7).
- R6: A byte with bit 7 at 0 and bits 4:0 all 0 is a register read. The next frame returns {flag, address, 5-bit value}. LED register bits 4:3 read as 1. The hardware register reads bit 2 as the bypass-monitor input, bit 1 as the PWM mode, and bits 4, 3 and 0 as 0.
- R7: When no read is pending, the response is the standard diagnosis byte: bit 7 is the flag, bit 6 the limp-home level, bit 5 is 0, and bits 4:0 are the channel error inputs. A byte with bit 7 at 0 and any nonzero bits 4:0 requests this byte, and so does any rejected frame.
- R8: In an accepted frame of 16 or 24 bits, only the last byte is decoded. The bytes sent earlier appear on `so` eight clocks after they were sent, following the response byte.
- R9: A write to address 10 with data bit 4 set returns every register to its reset value at the end of that frame and cancels any pending read.
- R10: A write to address 10 with data bit 0 set gives exactly one single-cycle `clrThermal` pulse. The bit is not stored and reads back as 0.
- R11: The frame that carries a read response can itself carry a write, and that write takes effect at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out (0 while not enabled) |
| soOe | output | 1 | Output enable for `so`; 0 means high impedance |
| errFlags | input | 5 | Per-channel error flags reported in the diagnosis byte |
| limpHome | input | 1 | Limp-home input level |
| bypassMon | input | 1 | Switch bypass monitor status |
| outEn | output | 5 | Per-channel output enables |
| ledMode | output | 3 | LED load mode for channels 0 to 2 |
| pwmMode | output | 1 | Parallel-input combine mode |
| clrThermal | output | 1 | Single-cycle pulse that clears the thermal latches |
| senseSel | output | 3 | Current-sense multiplexer select |

## Verification
The frame checker is driven with bit counts of 0, 5, 8, 12, 16 and 24. This separates a count that is correct modulo 8 from one that is merely nonzero, and a whole-byte frame from a partial one. Single-byte frames exercise writes, register reads and diagnosis requests, and the two-frame read is tested with a write carried in the response frame. Multi-byte frames put a write in an early byte and check that it has no effect while the same byte comes back on `so`, which shows that only the last byte is decoded. The pre-clock output is sampled with `si` at both levels and with the error flag at both levels, so that the OR can be told apart from either input alone.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
  localparam int FRAME_W = 8;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int NUM_CH  = 5;
  localparam int LED_CH  = 3;
  localparam int SEL_W   = 3;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT   = 2'b00,
    REG_LOAD  = 2'b01,
    REG_HW    = 2'b10,
    REG_SENSE = 2'b11
  } reg_addr_e;

  localparam logic [SEL_W-1:0] SENSE_DEFAULT = '1;

  // strobes from control to datapath
  typedef struct packed {
    logic csLow;
    logic csFall;
    logic frameEnd;
    logic frameOk;
    logic sclkRise;
    logic sclkFall;
    logic siBit;
    logic seenRise;
    logic terFlag;
  } spi_strobes_t;
endpackage

// File: rtl/chain_spi_sync.sv
module chain_spi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/chain_spi_ctrl.sv
module chain_spi_ctrl
  import chain_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         si,
  output spi_strobes_t stb
);
  logic [2:0] syncOut;
  logic csS, sclkS, siS;
  logic csPrev, sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic anyBit, terQ, seenRiseQ;
  logic csFall, csRise, sclkRise, sclkFall, frameOk;

  chain_spi_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
  ) sync_i (
    .clk(clk), .rstN(rstN), .din({csN, sclk, si}), .dout(syncOut)
  );

  assign csS   = syncOut[2];
  assign sclkS = syncOut[1];
  assign siS   = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkRise = ~csS & ~sclkPrev & sclkS;
  assign sclkFall = ~csS & sclkPrev & ~sclkS;
  assign frameOk  = anyBit & (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      anyBit    <= 1'b0;
      terQ      <= 1'b1;
      seenRiseQ <= 1'b0;
    end else begin
      if (csFall) begin
        bitCnt    <= '0;
        anyBit    <= 1'b0;
        seenRiseQ <= 1'b0;
      end else begin
        if (sclkFall) begin
          bitCnt <= bitCnt + 1'b1;
          anyBit <= 1'b1;
        end
        if (sclkRise) seenRiseQ <= 1'b1;
      end
      if (csRise) terQ <= ~frameOk;
    end
  end

  always_comb begin
    stb.csLow    = ~csS;
    stb.csFall   = csFall;
    stb.frameEnd = csRise;
    stb.frameOk  = frameOk;
    stb.sclkRise = sclkRise;
    stb.sclkFall = sclkFall;
    stb.siBit    = siS;
    stb.seenRise = seenRiseQ;
    stb.terFlag  = terQ;
  end
endmodule

// File: rtl/chain_spi_dpath.sv
module chain_spi_dpath
  import chain_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spi_strobes_t      stb,
  input  logic              si,
  input  logic [NUM_CH-1:0] errFlags,
  input  logic              limpHome,
  input  logic              bypassMon,
  output logic              so,
  output logic              soOe,
  output logic [NUM_CH-1:0] outEn,
  output logic [LED_CH-1:0] ledMode,
  output logic              pwmMode,
  output logic              clrThermal,
  output logic [SEL_W-1:0]  senseSel
);
  logic [FRAME_W-1:0] shiftReg, respByte;
  logic               soBit;
  logic               pendRead;
  reg_addr_e          pendAddr;
  logic [DATA_W-1:0]  readVal;
  logic               cmdWrite, cmdRead, hwReset;
  reg_addr_e          cmdAddr;
  logic [DATA_W-1:0]  cmdData;

  assign cmdWrite = shiftReg[FRAME_W-1];
  assign cmdAddr  = reg_addr_e'(shiftReg[FRAME_W-2 -: ADDR_W]);
  assign cmdData  = shiftReg[DATA_W-1:0];
  assign cmdRead  = ~cmdWrite & (cmdData == '0);
  assign hwReset  = cmdWrite & (cmdAddr == REG_HW) & cmdData[4];

  always_comb begin
    readVal = '0;
    unique case (pendAddr)
      REG_OUT:   readVal = DATA_W'(outEn);
      REG_LOAD:  readVal = {2'b11, ledMode};
      REG_HW:    readVal = {2'b00, bypassMon, pwmMode, 1'b0};
      REG_SENSE: readVal = DATA_W'(senseSel);
      default:   readVal = '0;
    endcase
    if (pendRead) respByte = {stb.terFlag, pendAddr, readVal};
    else          respByte = {stb.terFlag, limpHome, 1'b0, DATA_W'(errFlags)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      soBit    <= 1'b0;
    end else begin
      if (stb.csFall)        shiftReg <= respByte;
      else if (stb.sclkFall) shiftReg <= {shiftReg[FRAME_W-2:0], stb.siBit};
      if (stb.sclkRise)      soBit <= shiftReg[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEn      <= '0;
      ledMode    <= '0;
      pwmMode    <= 1'b0;
      senseSel   <= SENSE_DEFAULT;
      clrThermal <= 1'b0;
      pendRead   <= 1'b0;
      pendAddr   <= REG_OUT;
    end else begin
      clrThermal <= 1'b0;
      if (stb.frameEnd) begin
        pendRead <= 1'b0;
        if (stb.frameOk) begin
          if (hwReset) begin
            outEn    <= '0;
            ledMode  <= '0;
            pwmMode  <= 1'b0;
            senseSel <= SENSE_DEFAULT;
          end else if (cmdWrite) begin
            unique case (cmdAddr)
              REG_OUT:   outEn    <= cmdData[NUM_CH-1:0];
              REG_LOAD:  ledMode  <= cmdData[LED_CH-1:0];
              REG_HW: begin
                pwmMode    <= cmdData[1];
                clrThermal <= cmdData[0];
              end
              REG_SENSE: senseSel <= cmdData[SEL_W-1:0];
              default: ;
            endcase
          end else if (cmdRead) begin
            pendRead <= 1'b1;
            pendAddr <= cmdAddr;
          end
        end
      end
    end
  end

  assign soOe = stb.csLow;
  assign so   = soOe & (stb.seenRise ? soBit : (stb.terFlag | si));
endmodule

// File: rtl/chain_spi_regs.sv
module chain_spi_regs
  import chain_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              si,
  output logic              so,
  output logic              soOe,
  input  logic [NUM_CH-1:0] errFlags,
  input  logic              limpHome,
  input  logic              bypassMon,
  output logic [NUM_CH-1:0] outEn,
  output logic [LED_CH-1:0] ledMode,
  output logic              pwmMode,
  output logic              clrThermal,
  output logic [SEL_W-1:0]  senseSel
);
  spi_strobes_t stb;

  chain_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .stb(stb)
  );

  chain_spi_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .si(si),
    .errFlags(errFlags), .limpHome(limpHome), .bypassMon(bypassMon),
    .so(so), .soOe(soOe), .outEn(outEn), .ledMode(ledMode),
    .pwmMode(pwmMode), .clrThermal(clrThermal), .senseSel(senseSel)
  );
endmodule

// File: rtl/chain_spi_chk.sv
module chain_spi_chk
  import chain_spi_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input spi_strobes_t      stb,
  input logic [NUM_CH-1:0] outEn,
  input logic [LED_CH-1:0] ledMode,
  input logic [SEL_W-1:0]  senseSel,
  input logic              pwmMode,
  input logic              clrThermal
);
  // R5: registers only move at the end of a frame
  p_hold_mid_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.frameEnd |=> ($stable(outEn) && $stable(ledMode) && $stable(senseSel) && $stable(pwmMode)));

  // R3: a rejected frame leaves every register as it was
  p_drop_bad_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && !stb.frameOk) |=> ($stable(outEn) && $stable(ledMode) && $stable(senseSel) && $stable(pwmMode)));

  // R10: the clear pulse lasts one cycle
  p_clr_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    clrThermal |=> !clrThermal);

  // R10: the clear pulse follows an accepted frame only
  p_clr_after_ok_r10: assert property (@(posedge clk) disable iff (!rstN)
    clrThermal |-> $past(stb.frameEnd && stb.frameOk));
endmodule

bind chain_spi_regs chain_spi_chk chk_i (
  .clk(clk), .rstN(rstN), .stb(stb), .outEn(outEn), .ledMode(ledMode),
  .senseSel(senseSel), .pwmMode(pwmMode), .clrThermal(clrThermal)
);

// File: tb/chain_spi_regs_tb_top.sv
module chain_spi_regs_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, si = 1'b0;
  logic so, soOe;
  logic [4:0] errFlags = 5'b01011;
  logic limpHome = 1'b1;
  logic bypassMon = 1'b0;
  logic [4:0] outEn;
  logic [2:0] ledMode;
  logic pwmMode, clrThermal;
  logic [2:0] senseSel;

  int checks = 0;
  int fails = 0;
  int clrCount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chain_spi_regs dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .so(so), .soOe(soOe),
    .errFlags(errFlags), .limpHome(limpHome), .bypassMon(bypassMon),
    .outEn(outEn), .ledMode(ledMode), .pwmMode(pwmMode),
    .clrThermal(clrThermal), .senseSel(senseSel)
  );

  always @(posedge clk) if (clrThermal === 1'b1) clrCount++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic halfBit();
    repeat (8) @(posedge clk);
    #5;
  endtask

  // one frame of nbits, MSB of tx first; rx holds SO seen after each rising edge
  task automatic xfer(input int nbits, input logic [31:0] tx,
                      output logic [31:0] rx, output logic pre);
    rx = '0;
    si = (nbits > 0) ? tx[nbits-1] : 1'b0;
    csN = 1'b0;
    halfBit();
    pre = so;
    for (int i = nbits - 1; i >= 0; i--) begin
      si = tx[i];
      sclk = 1'b1;
      halfBit();
      rx[i] = so;
      sclk = 1'b0;
      halfBit();
    end
    csN = 1'b1;
    halfBit();
    halfBit();
  endtask

  task automatic testReset();
    chk("R1 soOe idle", soOe, 0);
    chk("R5 outEn reset", outEn, 0);
    chk("R5 ledMode reset", ledMode, 0);
    chk("R5 senseSel reset", senseSel, 3'd7);
    chk("R5 pwmMode reset", pwmMode, 0);
    chk("R10 no pulse at reset", clrCount, 0);
  endtask

  task automatic testFirstFrame();
    logic [31:0] rx; logic pre;
    xfer(8, 32'h01, rx, pre);
    chk("R2 R4 pre flag after reset", pre, 1);
    chk("R7 R4 diag first frame", rx[7:0], 8'hCB);
  endtask

  task automatic testWrite();
    logic [31:0] rx; logic pre;
    xfer(8, 32'h95, rx, pre);
    chk("R2 pre with si high", pre, 1);
    chk("R4 R7 diag flag cleared", rx[7:0], 8'h4B);
    chk("R5 outEn written", outEn, 5'b10101);
  endtask

  task automatic testRead();
    logic [31:0] rx; logic pre;
    xfer(8, 32'hA5, rx, pre);
    chk("R5 ledMode written", ledMode, 3'b101);
    xfer(8, 32'h20, rx, pre);
    chk("R2 pre with flag and si low", pre, 0);
    xfer(8, 32'hE3, rx, pre);
    chk("R6 read LED register", rx[7:0], 8'h3D);
    chk("R11 write in response frame", senseSel, 3'd3);
    xfer(8, 32'h01, rx, pre);
    chk("R7 diag when no read pending", rx[7:0], 8'h4B);
  endtask

  task automatic testHw();
    logic [31:0] rx; logic pre; int c0;
    bypassMon = 1'b1;
    c0 = clrCount;
    xfer(8, 32'hC2, rx, pre);
    chk("R5 pwmMode written", pwmMode, 1);
    chk("R10 no pulse without bit0", clrCount, c0);
    xfer(8, 32'h40, rx, pre);
    xfer(8, 32'h01, rx, pre);
    chk("R6 read hw register", rx[7:0], 8'h46);
    xfer(8, 32'hC3, rx, pre);
    chk("R10 one clear pulse", clrCount, c0 + 1);
    xfer(8, 32'h40, rx, pre);
    xfer(8, 32'h01, rx, pre);
    chk("R10 clear bit reads zero", rx[7:0], 8'h46);
  endtask

  task automatic testBadCount();
    logic [31:0] rx; logic pre;
    xfer(5, 32'h10, rx, pre);
    chk("R3 5-bit frame dropped", outEn, 5'b10101);
    xfer(8, 32'h01, rx, pre);
    chk("R3 R2 flag after 5 bits", pre, 1);
    chk("R4 flag in diag", rx[7:0], 8'hCB);
    xfer(12, 32'h9F0, rx, pre);
    chk("R3 12-bit frame dropped", senseSel, 3'd3);
    xfer(0, 32'h0, rx, pre);
    xfer(8, 32'h01, rx, pre);
    chk("R3 flag after empty frame", pre, 1);
    xfer(8, 32'h01, rx, pre);
    chk("R4 flag clears after good frame", pre, 0);
  endtask

  task automatic testChain();
    logic [31:0] rx; logic pre;
    xfer(16, 32'h9F8A, rx, pre);
    chk("R8 last byte decoded", outEn, 5'b01010);
    chk("R8 response byte", rx[15:8], 8'h4B);
    chk("R8 first byte passes through", rx[7:0], 8'h9F);
    xfer(24, 32'h8081A7, rx, pre);
    chk("R8 24-bit last byte decoded", ledMode, 3'b111);
    chk("R8 earlier bytes ignored", outEn, 5'b01010);
    chk("R8 24-bit pass through", rx[15:0], 16'h8081);
  endtask

  task automatic testIdle();
    logic [31:0] rx; logic pre;
    si = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; halfBit();
      sclk = 1'b0; halfBit();
    end
    chk("R1 soOe off while deselected", soOe, 0);
    xfer(8, 32'h01, rx, pre);
    chk("R1 idle pulses not counted", pre, 0);
    chk("R1 diag after idle pulses", rx[7:0], 8'h4B);
  endtask

  task automatic testSoftReset();
    logic [31:0] rx; logic pre;
    xfer(8, 32'hD0, rx, pre);
    chk("R9 outEn default", outEn, 0);
    chk("R9 ledMode default", ledMode, 0);
    chk("R9 senseSel default", senseSel, 3'd7);
    chk("R9 pwmMode default", pwmMode, 0);
    xfer(8, 32'h60, rx, pre);
    xfer(8, 32'h01, rx, pre);
    chk("R9 R6 read sense register", rx[7:0], 8'h67);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #5 rstN = 1'b1;
    halfBit();
    testReset();
    testFirstFrame();
    testWrite();
    testRead();
    testHw();
    testBadCount();
    testChain();
    testIdle();
    testSoftReset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule